// File: doc/BRIEF.md
# Pipelined Ternary Lookup Unit

This block holds a small ternary match table and answers lookups against it. A lookup key is 136 bits wide. It reaches the block over a 68-bit command bus in two back-to-back cycles. The first cycle (phase A) carries the low half and the opcode. The second cycle (phase B) carries the high half and the index of a comparand register pair. While it is being matched, the full key is also kept in that pair.

Each logical table entry spans two consecutive physical locations. The even location faces the low key half and the odd location faces the high key half. Each location holds a data word and a care mask, and each logical entry has a participation bit. The lowest-numbered participating entry that matches wins. Its even physical location is reported as the result address.

The result address comes out after a delay chosen by a size setting. The hit flag and valid strobe can be moved later than the address by a separate 3-bit setting, so downstream logic can be fed in the order it needs. The same command bus carries single-cycle commands to load and read the table.

Top module: `tsu_search_top`

## Requirements
- R1: A command with `cmd_op`=1 (lookup) in a cycle where no lookup is in progress is phase A, and `cmd_data` is taken as key bits 67:0. The next cycle is always phase B: `cmd_data` is taken as key bits 135:68, and `cmd_op` and `cmd_valid` in that cycle are ignored (no write, read or new lookup happens).
- R2: In phase B, the low key half is stored in the even comparand register and the high half in the odd comparand register of the pair selected by `cmd_creg`. Opcode 7 reads that pair back: `cmd_loc[0]`=0 returns the even register and 1 returns the odd register.
- R3: A table bit whose care-mask bit is 0 always matches. A bit whose mask bit is 1 matches only when it equals the key bit.
- R4: A logical entry takes part in a lookup only when its participation bit is 1. Reset clears all participation bits.
- R5: When more than one entry matches, the lowest-numbered entry wins. The result address is twice the entry number, so it is always even.
- R6: `res_addr` shows the result 4, 5 or 6 clock edges after the phase A edge, for `cfg_tsize` = 00, 01 and 10 respectively. The value 11 behaves as 10. In cycles that carry no result, `res_addr` is 0.
- R7: `res_hit` and `res_valid` appear exactly `cfg_hlat` cycles after `res_addr` (0 to 7). `res_valid` is a one-cycle pulse per lookup, and `res_hit` is never high without `res_valid`.
- R8: On a miss, `res_valid` still pulses, `res_hit` stays 0 and `res_addr` is 0.
- R9: A new lookup may start in the cycle right after phase B. Each lookup then produces its own result, in issue order, and the results of overlapping lookups do not interfere.
- R10: Opcodes 2 and 3 write `cmd_data` into the data word or the mask word of physical location `cmd_loc`. Opcodes 4 and 5 read the data word or the mask word back. Read data appears on `rd_data`, with `rd_valid` high for one cycle, on the edge after the command.
- R11: During reset, `res_valid`, `res_hit`, `res_addr` and `rd_valid` are 0, and all table words and comparand registers are cleared.
- R12: Opcode 6 writes `cmd_data[0]` into the participation bit of logical entry `cmd_loc[4:1]`. Opcode 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present (phase A and single-cycle commands) |
| cmd_op | input | 3 | Opcode: 0 none, 1 lookup, 2 write data, 3 write mask, 4 read data, 5 read mask, 6 set participation, 7 read comparand |
| cmd_data | input | 68 | Key half or write data |
| cmd_loc | input | 5 | Physical location, or comparand half select in bit 0 |
| cmd_creg | input | 3 | Comparand pair index (phase B, opcode 7) |
| cfg_tsize | input | 2 | Size setting that picks the result delay |
| cfg_hlat | input | 3 | Extra delay of hit flag and valid strobe |
| res_addr | output | 5 | Winning physical address |
| res_hit | output | 1 | Lookup matched |
| res_valid | output | 1 | Result strobe |
| rd_data | output | 68 | Read data |
| rd_valid | output | 1 | Read data strobe |

## Verification
A phase tracker that gets out of step shows up within one lookup. Either a write issued in phase B lands in the table, which the next read exposes, or a key is assembled from the wrong halves, which makes a known hit come out as a miss. A fault in the delay line is visible at the first result: the address or the strobe lands one cycle off the expected edge, or results from lookups issued two cycles apart bleed into each other. A wrong care-mask or participation decision turns up as a wrong winner in the very lookup that depends on it. Lookups that use duplicate and masked entries make the priority and don't-care paths show directly at `res_addr`.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_SEARCH  = 3'd1,
      OP_WR_DATA = 3'd2,
      OP_WR_MASK = 3'd3,
      OP_RD_DATA = 3'd4,
      OP_RD_MASK = 3'd5,
      OP_SET_VLD = 3'd6,
      OP_RD_CMP  = 3'd7
   } tsu_op_e;

   // Longest result delay selectable by the size setting.
   localparam int unsigned TSU_MAX_BASE_LAT = 6;

   // Edges from the phase A edge to the address output.
   function automatic logic [2:0] tsu_base_lat(input logic [1:0] tsize);
      case (tsize)
         2'b00:   return 3'd4;
         2'b01:   return 3'd5;
         default: return 3'd6;
      endcase
   endfunction

endpackage

// File: rtl/tsu_table.sv
module tsu_table #(
   parameter int HALF_W  = 68,
   parameter int ENTRIES = 16,
   parameter int LOC_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_is_mask,
   input  logic [LOC_W-1:0]  wr_loc,
   input  logic [HALF_W-1:0] wr_word,
   input  logic              vld_we,
   input  logic [LOC_W-2:0]  vld_idx,
   input  logic              vld_bit,
   input  logic [LOC_W-1:0]  rd_loc,
   output logic [HALF_W-1:0] rd_data_word,
   output logic [HALF_W-1:0] rd_mask_word,
   input  logic [HALF_W-1:0] key_lo,
   input  logic [HALF_W-1:0] key_hi,
   output logic [ENTRIES-1:0] match_vec
);
   localparam int LOCS = 2 * ENTRIES;

   logic [HALF_W-1:0] loc_data [LOCS];
   logic [HALF_W-1:0] loc_mask [LOCS];
   logic [ENTRIES-1:0] ent_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LOCS; i++) begin
            loc_data[i] <= '0;
            loc_mask[i] <= '0;
         end
         ent_vld <= '0;
      end else begin
         if (wr_en) begin
            if (wr_is_mask) loc_mask[wr_loc] <= wr_word;
            else            loc_data[wr_loc] <= wr_word;
         end
         if (vld_we) ent_vld[vld_idx] <= vld_bit;
      end
   end

   assign rd_data_word = loc_data[rd_loc];
   assign rd_mask_word = loc_mask[rd_loc];

   // One ternary comparator per logical entry; both halves must agree.
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic lo_ok, hi_ok;
      assign lo_ok = ((key_lo ^ loc_data[2*e])   & loc_mask[2*e])   == '0;
      assign hi_ok = ((key_hi ^ loc_data[2*e+1]) & loc_mask[2*e+1]) == '0;
      assign match_vec[e] = ent_vld[e] & lo_ok & hi_ok;
   end

endmodule

// File: rtl/tsu_first_match.sv
module tsu_first_match #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   // Scan from the top so the lowest set bit is assigned last and wins.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/tsu_result_pipe.sv
module tsu_result_pipe
   import tsu_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int HLAT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_hit,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [1:0]        cfg_tsize,
   input  logic [HLAT_W-1:0] cfg_hlat,
   output logic [ADDR_W-1:0] res_addr,
   output logic              res_hit,
   output logic              res_valid
);
   localparam int MAX_HLAT = (1 << HLAT_W) - 1;
   // Stage j holds a result captured j+1 edges after phase A.
   localparam int DEPTH    = int'(TSU_MAX_BASE_LAT) + MAX_HLAT;
   localparam int SEL_W    = $clog2(DEPTH);

   logic [DEPTH-1:0]  st_v;
   logic [DEPTH-1:0]  st_h;
   logic [ADDR_W-1:0] st_a [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_v <= '0;
         st_h <= '0;
         for (int j = 0; j < DEPTH; j++) st_a[j] <= '0;
      end else begin
         st_v <= {st_v[DEPTH-2:0], in_valid};
         st_h <= {st_h[DEPTH-2:0], in_valid & in_hit};
         st_a[0] <= in_valid ? in_addr : '0;
         for (int j = 1; j < DEPTH; j++) st_a[j] <= st_a[j-1];
      end
   end

   logic [SEL_W-1:0] addr_sel, flag_sel;
   assign addr_sel = SEL_W'(tsu_base_lat(cfg_tsize)) - SEL_W'(1);
   assign flag_sel = addr_sel + SEL_W'(cfg_hlat);

   assign res_addr  = st_a[addr_sel];
   assign res_hit   = st_h[flag_sel];
   assign res_valid = st_v[flag_sel];

endmodule

// File: rtl/tsu_search_top.sv
module tsu_search_top
   import tsu_pkg::*;
#(
   parameter  int HALF_W    = 68,
   parameter  int ENTRIES   = 16,
   parameter  int CMP_PAIRS = 8,
   parameter  int HLAT_W    = 3,
   localparam int LOC_W     = $clog2(2 * ENTRIES),
   localparam int IDX_W     = $clog2(ENTRIES),
   localparam int CREG_W    = $clog2(CMP_PAIRS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [HALF_W-1:0] cmd_data,
   input  logic [LOC_W-1:0]  cmd_loc,
   input  logic [CREG_W-1:0] cmd_creg,
   input  logic [1:0]        cfg_tsize,
   input  logic [HLAT_W-1:0] cfg_hlat,
   output logic [LOC_W-1:0]  res_addr,
   output logic              res_hit,
   output logic              res_valid,
   output logic [HALF_W-1:0] rd_data,
   output logic              rd_valid
);
   // Elaboration-time parameter checks.
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two, at least 2");
   end
   if (CMP_PAIRS < 2 || (CMP_PAIRS & (CMP_PAIRS - 1)) != 0) begin : g_bad_pairs
      $error("CMP_PAIRS must be a power of two, at least 2");
   end
   if (HALF_W < 1 || HLAT_W < 1) begin : g_bad_widths
      $error("HALF_W and HLAT_W must be positive");
   end

   tsu_op_e op;
   assign op = tsu_op_e'(cmd_op);

   logic phase_b;
   logic [HALF_W-1:0] key_lo;
   logic start_a, cmd_ok;

   assign start_a = cmd_valid && !phase_b && (op == OP_SEARCH);
   assign cmd_ok  = cmd_valid && !phase_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_b <= 1'b0;
         key_lo  <= '0;
      end else begin
         phase_b <= start_a;
         if (start_a) key_lo <= cmd_data;
      end
   end

   // Comparand pairs, loaded with the whole key in phase B.
   logic [HALF_W-1:0] cmp_even [CMP_PAIRS];
   logic [HALF_W-1:0] cmp_odd  [CMP_PAIRS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < CMP_PAIRS; i++) begin
            cmp_even[i] <= '0;
            cmp_odd[i]  <= '0;
         end
      end else if (phase_b) begin
         cmp_even[cmd_creg] <= key_lo;
         cmp_odd[cmd_creg]  <= cmd_data;
      end
   end

   logic [HALF_W-1:0]  tbl_rd_data, tbl_rd_mask;
   logic [ENTRIES-1:0] match_vec;

   tsu_table #(
      .HALF_W (HALF_W),
      .ENTRIES(ENTRIES),
      .LOC_W  (LOC_W)
   ) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (cmd_ok && (op == OP_WR_DATA || op == OP_WR_MASK)),
      .wr_is_mask  (op == OP_WR_MASK),
      .wr_loc      (cmd_loc),
      .wr_word     (cmd_data),
      .vld_we      (cmd_ok && (op == OP_SET_VLD)),
      .vld_idx     (cmd_loc[LOC_W-1:1]),
      .vld_bit     (cmd_data[0]),
      .rd_loc      (cmd_loc),
      .rd_data_word(tbl_rd_data),
      .rd_mask_word(tbl_rd_mask),
      .key_lo      (key_lo),
      .key_hi      (cmd_data),
      .match_vec   (match_vec)
   );

   logic             found;
   logic [IDX_W-1:0] win_idx;
   logic [LOC_W-1:0] win_addr;

   tsu_first_match #(
      .N    (ENTRIES),
      .IDX_W(IDX_W)
   ) u_first (
      .vec  (match_vec),
      .found(found),
      .idx  (win_idx)
   );

   assign win_addr = found ? {win_idx, 1'b0} : '0;

   tsu_result_pipe #(
      .ADDR_W(LOC_W),
      .HLAT_W(HLAT_W)
   ) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (phase_b),
      .in_hit   (found),
      .in_addr  (win_addr),
      .cfg_tsize(cfg_tsize),
      .cfg_hlat (cfg_hlat),
      .res_addr (res_addr),
      .res_hit  (res_hit),
      .res_valid(res_valid)
   );

   // Read port: one registered stage after the command.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         if (cmd_ok) begin
            case (op)
               OP_RD_DATA: begin rd_valid <= 1'b1; rd_data <= tbl_rd_data; end
               OP_RD_MASK: begin rd_valid <= 1'b1; rd_data <= tbl_rd_mask; end
               OP_RD_CMP: begin
                  rd_valid <= 1'b1;
                  rd_data  <= cmd_loc[0] ? cmp_odd[cmd_creg] : cmp_even[cmd_creg];
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/tsu_search_sva.sv
module tsu_search_sva #(
   parameter int LOC_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [2:0]       cmd_op,
   input logic             phase_b,
   input logic [LOC_W-1:0] res_addr,
   input logic             res_hit,
   input logic             res_valid,
   input logic             rd_valid
);
   // A phase B cycle is never followed by another phase B cycle.
   assert_single_phase_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
      phase_b |=> !phase_b);

   // Winning addresses are always even.
   assert_even_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_addr[0] == 1'b0);

   // The hit flag is only raised together with the strobe.
   assert_hit_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_valid);

   // Lookups are at least two cycles apart, so strobes never touch.
   assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // An accepted read command produces a read strobe on the next edge.
   assert_read_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !phase_b && (cmd_op == 3'd4 || cmd_op == 3'd5 || cmd_op == 3'd7))
      |=> rd_valid);

   // Outputs are quiet right after a reset edge.
   assert_reset_quiet_R11: assert property (@(posedge clk)
      !rst_n |=> (!res_valid && !res_hit && !rd_valid && res_addr == '0));

endmodule

bind tsu_search_top tsu_search_sva #(.LOC_W(LOC_W)) u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .cmd_op   (cmd_op),
   .phase_b  (phase_b),
   .res_addr (res_addr),
   .res_hit  (res_hit),
   .res_valid(res_valid),
   .rd_valid (rd_valid)
);

// File: tb/test_tsu_search_top.sv
module test_tsu_search_top;
   localparam int HW = 68;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = 3'd0;
   logic [HW-1:0] cmd_data = '0;
   logic [4:0]    cmd_loc = '0;
   logic [2:0]    cmd_creg = '0;
   logic [1:0]    cfg_tsize = 2'b10;
   logic [2:0]    cfg_hlat = 3'd0;
   logic [4:0]    res_addr;
   logic          res_hit, res_valid;
   logic [HW-1:0] rd_data;
   logic          rd_valid;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   tsu_search_top i_tsu_search_top (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .cmd_loc(cmd_loc), .cmd_creg(cmd_creg),
      .cfg_tsize(cfg_tsize), .cfg_hlat(cfg_hlat), .res_addr(res_addr),
      .res_hit(res_hit), .res_valid(res_valid), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   // Vector table: key halves, settings and the expected outcome.
   localparam int NV = 8;
   localparam logic [HW-1:0] V_LO [NV] = '{68'h0, 68'h7, 68'h3, 68'h5, 68'h9A, 68'hF, 68'h4, 68'h8F};
   localparam logic [HW-1:0] V_HI [NV] = '{68'h0, 68'h15, 68'h9, 68'hF, 68'h123456, 68'h2D, 68'hD, 68'h0};
   localparam logic [1:0] V_TS [NV] = '{2'b00, 2'b01, 2'b10, 2'b10, 2'b11, 2'b00, 2'b01, 2'b10};
   localparam logic [2:0] V_HL [NV] = '{3'd0, 3'd2, 3'd0, 3'd3, 3'd7, 3'd1, 3'd0, 3'd5};
   localparam logic V_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
   localparam logic [4:0] V_ADDR [NV] = '{5'd0, 5'd14, 5'd6, 5'd0, 5'd18, 5'd30, 5'd0, 5'd0};

   // Table contents used by the bench.
   function automatic logic [HW-1:0] f_lo(int e);
      if (e == 9)  return 68'h90;
      if (e == 12) return 68'h3;
      return HW'(e);
   endfunction
   function automatic logic [HW-1:0] f_hi(int e);
      if (e == 12) return 68'h9;
      return HW'(3 * e);
   endfunction
   function automatic logic [HW-1:0] f_mlo(int e);
      return (e == 9) ? ~68'hF : {HW{1'b1}};
   endfunction
   function automatic logic [HW-1:0] f_mhi(int e);
      return (e == 9) ? '0 : {HW{1'b1}};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [HW-1:0] act, input logic [HW-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [HW-1:0] d, input logic [4:0] loc, input logic [2:0] cr);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_loc = loc; cmd_creg = cr;
   endtask

   task automatic idle();
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
   endtask

   task automatic read_chk(input logic [2:0] op, input logic [4:0] loc, input logic [2:0] cr,
                           input logic [HW-1:0] exp, input string req);
      drive(op, '0, loc, cr);
      idle();
      chk(rd_valid == 1'b1, {req, " rd_valid"}, HW'(rd_valid), 68'h1);
      chk(rd_data == exp, {req, " rd_data"}, rd_data, exp);
   endtask

   task automatic search_chk(input logic [HW-1:0] lo, input logic [HW-1:0] hi, input logic [2:0] cr,
                             input logic [1:0] ts, input logic [2:0] hl, input logic [2:0] b_op,
                             input logic exp_hit, input logic [4:0] exp_addr, input string req);
      int lat;
      lat = (ts == 2'b00) ? 4 : (ts == 2'b01) ? 5 : 6;
      cfg_tsize = ts; cfg_hlat = hl;
      drive(3'd1, lo, 5'd0, 3'd0);
      drive(b_op, hi, 5'd2, cr);
      idle();
      repeat (lat - 2) @(negedge clk);
      chk(res_addr == 5'd0 && res_valid == 1'b0, {req, " R6 quiet before result"},
          HW'({res_valid, res_addr}), 68'h0);
      @(negedge clk);
      chk(res_addr == exp_addr, {req, " R6 res_addr"}, HW'(res_addr), HW'(exp_addr));
      if (hl != 3'd0) begin
         chk(res_valid == 1'b0, {req, " R7 strobe not early"}, HW'(res_valid), 68'h0);
         repeat (int'(hl)) @(negedge clk);
      end
      chk(res_valid == 1'b1, {req, " R7 res_valid"}, HW'(res_valid), 68'h1);
      chk(res_hit == exp_hit, {req, " R8 res_hit"}, HW'(res_hit), HW'(exp_hit));
      @(negedge clk);
      chk(res_valid == 1'b0, {req, " R7 single pulse"}, HW'(res_valid), 68'h0);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: outputs quiet during reset
      chk(res_valid == 0 && res_hit == 0 && res_addr == 0 && rd_valid == 0, "R11 reset outputs",
          HW'({res_valid, res_hit, res_addr, rd_valid}), 68'h0);
      rst_n = 1'b1;
      // R11: storage cleared; R4: participation cleared, so cleared words do not match
      read_chk(3'd4, 5'd0, 3'd0, 68'h0, "R11 table data cleared");
      read_chk(3'd5, 5'd1, 3'd0, 68'h0, "R11 table mask cleared");
      read_chk(3'd7, 5'd1, 3'd3, 68'h0, "R11 comparand cleared");
      search_chk(68'h0, 68'h0, 3'd0, 2'b10, 3'd0, 3'd0, 1'b0, 5'd0, "R4 no entry participates");

      // Load the table (R10, R12)
      for (int e = 0; e < 16; e++) begin
         drive(3'd2, f_lo(e), 5'(2 * e), 3'd0);
         drive(3'd2, f_hi(e), 5'(2 * e + 1), 3'd0);
         drive(3'd3, f_mlo(e), 5'(2 * e), 3'd0);
         drive(3'd3, f_mhi(e), 5'(2 * e + 1), 3'd0);
         drive(3'd6, (e == 5) ? 68'h0 : 68'h1, 5'(2 * e), 3'd0);
      end
      idle();
      read_chk(3'd4, 5'd18, 3'd0, 68'h90, "R10 read data word");
      read_chk(3'd5, 5'd18, 3'd0, ~68'hF, "R10 read mask word");
      read_chk(3'd4, 5'd25, 3'd0, 68'h9, "R10 read odd data word");

      // Vector walk: R3 masked bits, R4 invalid entry, R5 priority, R6/R7 delays, R8 misses
      for (int v = 0; v < NV; v++) begin
         search_chk(V_LO[v], V_HI[v], 3'(v), V_TS[v], V_HL[v], 3'd0, V_HIT[v], V_ADDR[v],
                    $sformatf("vec%0d R3 R5", v));
      end

      // R2: each vector left its key in comparand pair v
      for (int v = 0; v < NV; v++) begin
         read_chk(3'd7, 5'd0, 3'(v), V_LO[v], $sformatf("R2 even pair %0d", v));
         read_chk(3'd7, 5'd1, 3'(v), V_HI[v], $sformatf("R2 odd pair %0d", v));
      end

      // R1: write opcode presented in phase B is ignored; key halves in the right order
      search_chk(68'h1, 68'h3, 3'd0, 2'b10, 3'd0, 3'd2, 1'b1, 5'd2, "R1 phase B key");
      read_chk(3'd4, 5'd2, 3'd0, 68'h1, "R1 phase B write ignored");

      // R9: back-to-back lookups with overlapping results
      cfg_tsize = 2'b10; cfg_hlat = 3'd2;
      for (int n = 0; n < 16; n++) begin
         @(negedge clk);
         if (n >= 2) begin
            logic [4:0] ea;
            logic       ev, eh;
            ea = (n == 7) ? 5'd2 : (n == 11) ? 5'd18 : 5'd0;
            ev = (n == 9 || n == 11 || n == 13);
            eh = (n == 9 || n == 13);
            chk(res_addr == ea, $sformatf("R9 addr cycle %0d", n), HW'(res_addr), HW'(ea));
            chk(res_valid == ev, $sformatf("R9 valid cycle %0d", n), HW'(res_valid), HW'(ev));
            chk(res_hit == eh, $sformatf("R9 hit cycle %0d", n), HW'(res_hit), HW'(eh));
         end
         case (n)
            0: begin cmd_valid = 1; cmd_op = 3'd1; cmd_data = 68'h1; end
            1: begin cmd_op = 3'd0; cmd_data = 68'h3; end
            2: begin cmd_op = 3'd1; cmd_data = 68'h5; end
            3: begin cmd_op = 3'd0; cmd_data = 68'hF; end
            4: begin cmd_op = 3'd1; cmd_data = 68'h95; end
            5: begin cmd_op = 3'd0; cmd_data = 68'h0; end
            default: begin cmd_valid = 0; cmd_op = 3'd0; end
         endcase
      end

      // R12: participation bits
      drive(3'd6, 68'h1, 5'd10, 3'd0);
      idle();
      search_chk(68'h5, 68'hF, 3'd0, 2'b10, 3'd0, 3'd0, 1'b1, 5'd10, "R12 entry enabled");
      drive(3'd6, 68'h0, 5'd0, 3'd0);
      drive(3'd0, 68'h1, 5'd0, 3'd0);
      idle();
      search_chk(68'h0, 68'h0, 3'd0, 2'b01, 3'd1, 3'd0, 1'b0, 5'd0, "R12 entry disabled R8");

      finish_run();
   end

endmodule